// File: doc/BRIEF.md
# Two-Wire Command Receiver for a Converter Register File

This block is the bus-side front end of a multi-channel converter. It watches the serial clock and data lines of a two-wire (I2C) bus with its own system clock and finds START and STOP conditions. It answers the target address formed from a fixed upper part and a four-bit strap input. It also answers a shared broadcast address, but only for writes. A write transfer carries a command byte that names a register, then a high and a low data byte. The two data bytes are held in a staging register. They are handed to the register file as one strobe during an acknowledge slot, never while bits are still arriving.

The pin-side logic needs an open-drain pad. `sda_oe` high means the pad pulls the data line low. A read transfer sends back the 16-bit word that the register file returns for the last command written. The high byte goes first, then the low byte. The bytes keep alternating for as long as the master acknowledges. A repeated START or a STOP at any point drops a partly received pair and sends the block back to waiting for an address.

Top module: `i2c_cmd_target`

## Requirements
- R1: After reset, `sda_oe` is 0, `wr_stb` is 0 and `wr_data` is 0.
- R2: An address byte whose upper seven bits equal binary 001 followed by `strap_i[3:0]`, with bit 0 (R/W) equal to 0, is acknowledged. The line is held low for the whole ninth clock pulse.
- R3: The address byte 0x28 (seven-bit 0010100, write) is acknowledged whatever the strap value.
- R4: The byte 0x29 (broadcast address with R/W = 1) is not acknowledged when the strap is not 0100.
- R5: After an address that does not match, the line stays released and no later byte is acknowledged until the next START.
- R6: In a write, the byte after the address is a command, then a high byte and a low byte. One `wr_stb` pulse carries `wr_cmd` equal to the command and `wr_data` equal to {high, low}. The pulse comes in the acknowledge slot of the low byte, while the block pulls the line low.
- R7: Further byte pairs in the same write produce further strobes with the same command.
- R8: A STOP or a repeated START before a pair is complete produces no strobe. The next transfer works normally.
- R9: Every command and data byte of an addressed write is acknowledged.
- R10: In a read to the own address (R/W = 1), the block sends the register word for `rd_cmd` MSB first. It sends bits 15:8, then 7:0, and alternates while the master acknowledges. Each bit is held steady while the clock is high.
- R11: A not-acknowledge from the master ends the read and releases the line.
- R12: `wr_data` changes only together with a `wr_stb` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen at the pad, asynchronous |
| strap_i | input | 4 | Low four address bits |
| rd_data_i | input | 16 | Register word for `rd_cmd`, from the register file |
| sda_oe | output | 1 | 1 = pull the data line low |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_cmd | output | 8 | Register selected by the command byte |
| wr_data | output | 16 | Word written with the strobe |
| rd_cmd | output | 8 | Last command received, selects the read word |

## Verification
The hardest situations to reach are the aborts inside a pair. In one, a STOP lands after three bits of the low byte. In the other, a repeated START follows a fully acknowledged high byte. Either must leave no strobe and no trace in the next transfer. The bench drives a bit-level bus master that can cut a byte short after any number of bits. It also issues START from the clock-low state, so both cases come up in sequence. A scoreboard then proves that no stray strobe appears and that the following write still lands. The read path is driven by a repeated START after a command-only write, and the master acknowledges twice before it not-acknowledges. This checks that the word wraps back to its high byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    localparam int BYTE_W   = 8;
    localparam int DATA_W   = 2 * BYTE_W;
    localparam int STRAP_W  = 4;
    localparam int CNT_W    = $clog2(BYTE_W) + 1;
    localparam logic [6-STRAP_W:0] ADDR_TOP   = 3'b001;
    localparam logic [6:0]         BCAST_ADDR = 7'h14;

    typedef enum logic [2:0] {
        PH_IDLE, PH_RX, PH_RXACK, PH_TX, PH_TXACK
    } phase_t;

    typedef enum logic [1:0] {
        SL_ADDR, SL_CMD, SL_HI, SL_LO
    } slot_t;

    typedef struct packed {
        phase_t             ph;
        slot_t              slot;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  sh;
        logic [BYTE_W-1:0]  hi;
        logic [BYTE_W-1:0]  cmd;
        logic [BYTE_W-1:0]  tx;
        logic [DATA_W-1:0]  data;
        logic               rw;
        logic               tx_lo;
        logic               mack;
        logic               sda_oe;
        logic               stb;
    } eng_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [SYNC_STAGES-1:0] scl_sh_d, scl_sh_q, sda_sh_d, sda_sh_q;
    logic scl_p_q, sda_p_q;

    always_comb begin
        scl_sh_d = {scl_sh_q[SYNC_STAGES-2:0], scl_i};
        sda_sh_d = {sda_sh_q[SYNC_STAGES-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh_q <= '1;
            sda_sh_q <= '1;
            scl_p_q  <= 1'b1;
            sda_p_q  <= 1'b1;
        end else begin
            scl_sh_q <= scl_sh_d;
            sda_sh_q <= sda_sh_d;
            scl_p_q  <= scl_sh_q[SYNC_STAGES-1];
            sda_p_q  <= sda_sh_q[SYNC_STAGES-1];
        end
    end

    assign scl_lvl   = scl_sh_q[SYNC_STAGES-1];
    assign sda_lvl   = sda_sh_q[SYNC_STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_p_q;
    assign scl_fall  = ~scl_lvl & scl_p_q;
    assign start_evt = scl_lvl & scl_p_q & sda_p_q & ~sda_lvl;
    assign stop_evt  = scl_lvl & scl_p_q & ~sda_p_q & sda_lvl;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sda_lvl,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_evt,
    input  logic               stop_evt,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [DATA_W-1:0]  rd_data_i,
    output logic               sda_oe,
    output logic               wr_stb,
    output logic [BYTE_W-1:0]  wr_cmd,
    output logic [DATA_W-1:0]  wr_data,
    output logic [BYTE_W-1:0]  rd_cmd
);
    localparam logic [CNT_W-1:0] BITS = CNT_W'(BYTE_W);

    eng_t q, d;
    logic [BYTE_W-1:0] nxt;
    logic own_hit, bcast_hit;

    assign own_hit   = (q.sh[BYTE_W-1:1] == {ADDR_TOP, strap_i});
    assign bcast_hit = (q.sh == {BCAST_ADDR, 1'b0});

    always_comb begin
        d     = q;
        d.stb = 1'b0;
        nxt   = q.tx_lo ? rd_data_i[BYTE_W-1:0] : rd_data_i[DATA_W-1 -: BYTE_W];
        if (stop_evt) begin
            d.ph     = PH_IDLE;
            d.sda_oe = 1'b0;
        end else if (start_evt) begin
            d.ph     = PH_RX;
            d.slot   = SL_ADDR;
            d.cnt    = '0;
            d.sda_oe = 1'b0;
        end else begin
            case (q.ph)
                PH_RX: begin
                    if (scl_rise && q.cnt != BITS) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_lvl};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == BITS) begin
                        d.ph     = PH_RXACK;
                        d.sda_oe = 1'b1;
                        case (q.slot)
                            SL_ADDR: begin
                                if (own_hit || bcast_hit) begin
                                    d.rw   = q.sh[0];
                                    d.slot = SL_CMD;
                                end else begin
                                    d.ph     = PH_IDLE;
                                    d.sda_oe = 1'b0;
                                end
                            end
                            SL_CMD: begin
                                d.cmd  = q.sh;
                                d.slot = SL_HI;
                            end
                            SL_HI: begin
                                d.hi   = q.sh;
                                d.slot = SL_LO;
                            end
                            default: begin
                                d.data = {q.hi, q.sh};
                                d.stb  = 1'b1;
                                d.slot = SL_HI;
                            end
                        endcase
                    end
                end
                PH_RXACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.ph     = PH_TX;
                            d.tx     = rd_data_i[DATA_W-1 -: BYTE_W];
                            d.tx_lo  = 1'b1;
                            d.sda_oe = ~rd_data_i[DATA_W-1];
                        end else begin
                            d.ph     = PH_RX;
                            d.sda_oe = 1'b0;
                        end
                    end
                end
                PH_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == BITS - 1'b1) begin
                            d.ph     = PH_TXACK;
                            d.sda_oe = 1'b0;
                            d.mack   = 1'b0;
                        end else begin
                            d.tx     = {q.tx[BYTE_W-2:0], 1'b0};
                            d.sda_oe = ~q.tx[BYTE_W-2];
                            d.cnt    = q.cnt + 1'b1;
                        end
                    end
                end
                PH_TXACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.ph     = PH_TX;
                            d.tx     = nxt;
                            d.tx_lo  = ~q.tx_lo;
                            d.sda_oe = ~nxt[BYTE_W-1];
                            d.cnt    = '0;
                        end else begin
                            d.ph = PH_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ph: PH_IDLE, slot: SL_ADDR, default: '0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe  = q.sda_oe;
    assign wr_stb  = q.stb;
    assign wr_cmd  = q.cmd;
    assign wr_data = q.data;
    assign rd_cmd  = q.cmd;
endmodule

// File: rtl/i2c_cmd_target.sv
module i2c_cmd_target
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [DATA_W-1:0]  rd_data_i,
    output logic               sda_oe,
    output logic               wr_stb,
    output logic [BYTE_W-1:0]  wr_cmd,
    output logic [DATA_W-1:0]  wr_data,
    output logic [BYTE_W-1:0]  rd_cmd
);
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_evt(start_evt),
        .stop_evt (stop_evt)
    );

    i2c_tgt_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_evt(start_evt),
        .stop_evt (stop_evt),
        .strap_i  (strap_i),
        .rd_data_i(rd_data_i),
        .sda_oe   (sda_oe),
        .wr_stb   (wr_stb),
        .wr_cmd   (wr_cmd),
        .wr_data  (wr_data),
        .rd_cmd   (rd_cmd)
    );
endmodule

// File: rtl/i2c_cmd_target_chk.sv
module i2c_cmd_target_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_lvl,
    input logic              stop_evt,
    input logic              sda_oe,
    input logic              wr_stb,
    input logic [DATA_W-1:0] wr_data
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!sda_oe && !wr_stb));

    a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    a_r6_strobe_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> sda_oe);

    a_r12_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wr_data) |-> wr_stb);

    a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_lvl);

    a_r8_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (!sda_oe && !wr_stb));
endmodule

bind i2c_cmd_target i2c_cmd_target_chk #(.DATA_W(16)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_lvl (scl_lvl),
    .stop_evt(stop_evt),
    .sda_oe  (sda_oe),
    .wr_stb  (wr_stb),
    .wr_data (wr_data)
);

// File: tb/i2c_cmd_target_test.sv
module i2c_cmd_target_test;
    localparam int Q = 20;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, scl, sda_m, sda_bus;
    logic [3:0]  strap;
    logic [15:0] rd_data, wr_data;
    logic [7:0]  wr_cmd, rd_cmd;
    logic        sda_oe, wr_stb;

    assign sda_bus = sda_m & ~sda_oe;
    assign rd_data = {rd_cmd, ~rd_cmd};

    i2c_cmd_target uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .strap_i(strap), .rd_data_i(rd_data), .sda_oe(sda_oe),
        .wr_stb(wr_stb), .wr_cmd(wr_cmd), .wr_data(wr_data), .rd_cmd(rd_cmd)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [23:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_c();
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic stop_c();
        sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0; tick(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        bit a1, a2;
        send_bits(b, 8);
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(2);
        a1 = ~sda_bus; tick(Q - 4);
        a2 = ~sda_bus; tick(2);
        scl = 1'b0; tick(Q);
        chk((a1 & a2) == exp_ack, req, {a1, a2}, {exp_ack, exp_ack});
    endtask

    task automatic recv_byte(input bit mack, input logic [7:0] exp, input string req);
        logic [7:0] b;
        bit steady;
        steady = 1'b1;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); scl = 1'b1; tick(Q / 2);
            b[i] = sda_bus; tick(Q / 2);
            if (sda_bus != b[i]) steady = 1'b0;
            scl = 1'b0;
        end
        sda_m = ~mack; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0; tick(Q);
        sda_m = 1'b1;
        chk(b == exp && steady, req, {steady, b}, {1'b1, exp});
    endtask

    // scoreboard monitor
    initial begin
        logic [23:0] e;
        forever begin
            @(negedge clk);
            if (wr_stb) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected strobe", {wr_cmd, wr_data}, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk({wr_cmd, wr_data} == e, "R6/R7 strobe", {wr_cmd, wr_data}, e);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; strap = 4'b1010;
        tick(5); rst_n = 1'b1; tick(5);
        chk(!sda_oe && !wr_stb && wr_data == 0, "R1 reset", {sda_oe, wr_stb, wr_data}, 0);

        // R2/R9/R6: own address write
        start_c();
        send_byte(8'h34, 1'b1, "R2 own address ack");
        exp_q.push_back({8'h05, 16'hA53C});
        send_byte(8'h05, 1'b1, "R9 command ack");
        send_byte(8'hA5, 1'b1, "R9 high ack");
        send_byte(8'h3C, 1'b1, "R9 low ack");
        stop_c();

        // R3/R7: broadcast write, two pairs
        start_c();
        send_byte(8'h28, 1'b1, "R3 broadcast ack");
        exp_q.push_back({8'h11, 16'h1234});
        exp_q.push_back({8'h11, 16'h5678});
        send_byte(8'h11, 1'b1, "R9 command ack");
        send_byte(8'h12, 1'b1, "R9 data ack");
        send_byte(8'h34, 1'b1, "R9 data ack");
        send_byte(8'h56, 1'b1, "R7 second pair ack");
        send_byte(8'h78, 1'b1, "R7 second pair ack");
        stop_c();

        // R5: mismatch, then ignore
        start_c();
        send_byte(8'h36, 1'b0, "R5 mismatch nack");
        send_byte(8'h34, 1'b0, "R5 ignored byte");
        send_byte(8'h00, 1'b0, "R5 ignored byte");
        stop_c();

        // R4: broadcast read refused
        start_c();
        send_byte(8'h29, 1'b0, "R4 broadcast read nack");
        send_byte(8'h05, 1'b0, "R4 ignored after refusal");
        stop_c();

        // R8: stop in low byte, repeated start after high byte
        start_c();
        send_byte(8'h34, 1'b1, "R8 address ack");
        send_byte(8'h22, 1'b1, "R8 command ack");
        send_byte(8'h99, 1'b1, "R8 high ack");
        send_bits(8'hF0, 3);
        stop_c();
        start_c();
        send_byte(8'h34, 1'b1, "R8 address ack");
        send_byte(8'h22, 1'b1, "R8 command ack");
        send_byte(8'hFF, 1'b1, "R8 high ack");
        start_c();
        send_byte(8'h34, 1'b1, "R8 address after restart");
        exp_q.push_back({8'h33, 16'h0102});
        send_byte(8'h33, 1'b1, "R8 command ack");
        send_byte(8'h01, 1'b1, "R8 high ack");
        send_byte(8'h02, 1'b1, "R8 low ack");
        stop_c();
        tick(10);
        chk(exp_q.size() == 0, "R6 all strobes seen", exp_q.size(), 0);
        chk(wr_data == 16'h0102, "R12 data held", wr_data, 16'h0102);

        // R10/R11: read back through repeated start
        start_c();
        send_byte(8'h34, 1'b1, "R10 address ack");
        send_byte(8'h4C, 1'b1, "R10 command ack");
        start_c();
        send_byte(8'h35, 1'b1, "R10 read address ack");
        recv_byte(1'b1, 8'h4C, "R10 high byte");
        recv_byte(1'b1, 8'hB3, "R10 low byte");
        recv_byte(1'b0, 8'h4C, "R10 wrap to high byte");
        chk(!sda_oe && sda_bus, "R11 released after nack", {sda_oe, sda_bus}, 2'b01);
        stop_c();
        tick(10);
        chk(wr_data == 16'h0102, "R12 data held after read", wr_data, 16'h0102);
        chk(exp_q.size() == 0, "R8 no extra strobes", exp_q.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule